// File: doc/BRIEF.md
# Programmable 16-bit Reload Timer

This block is a single 16-bit down-counter that software controls through a small byte-wide register port. The counter steps down once per tick. A tick comes either from a prescaled system clock (divide by 4, 16, 64 or 256) or from rising edges on an external event pin. When the count steps from 0001h to 0000h the timer has reached end-of-count. In continuous mode it then reloads and keeps running. In one-shot mode it parks at zero and turns itself off.

The count and the reload value share one pair of byte addresses. Reads return the live count and writes set the reload value. Reading the low byte captures the high byte of the count at the same moment, so two byte reads give a consistent 16-bit value. A restart bit in the control register copies the reload value into the counter on the clock edge after it is written. End-of-count sets a sticky status flag, which is cleared by reading it. While the interrupt enable is set, that flag drives the interrupt request. Edges on the event pin are counted with a fixed latency of five clocks. The event rate must stay below half the clock rate.

Top module: `reload_timer16`

## Requirements
- R1: After reset the control, source, count, status and reload value all read or hold zero, and `irq` is low.
- R2: Writing address 2 sets reload bits [7:0] and writing address 3 sets reload bits [15:8]. These writes leave the running count unchanged, and reads of addresses 2 and 3 return count data, not the reload value.
- R3: Writing control (address 0) with bit 1 set loads the reload value into the counter on the next rising clock edge. After that edge, bit 1 reads back as 0.
- R4: With control bit 0 set and source bit 0 (address 1) clear, the count steps down by one every N clocks. N is 4, 16, 64 or 256 for control bits [4:3] equal to 0, 1, 2 or 3. The first step comes N clocks after the edge that captured the enable.
- R5: With source bit 0 set, each rising edge of `evt_pin` produces exactly one decrement, on the fifth rising clock edge after the pin edge. Falling edges and the prescaler produce no step.
- R6: With control bit 2 set (continuous), a tick at count 0001h loads the reload value instead of 0000h.
- R7: With control bit 2 clear (one-shot), a tick at count 0001h gives 0000h and clears control bit 0, and the count then stays still.
- R8: End-of-count sets status bit 0 (address 4). Reading address 4 clears it unless a new end-of-count happens in the same cycle.
- R9: `irq` is high exactly while status bit 0 and control bit 6 are both set.
- R10: Clearing control bit 0 freezes the count at its present value, with no reload.
- R11: Reading address 2 latches count bits [15:8]. Reads of address 3 return that latched byte, even after the count has moved on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| rd_en | input | 1 | Read strobe; triggers read side effects (latch, flag clear) |
| addr | input | 3 | Register address (0 control, 1 source, 2 count/reload low, 3 count/reload high, 4 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| evt_pin | input | 1 | External event input, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The counter is driven by each prescaler setting in turn. The bench checks that the first step and the next step both land exactly N clocks apart, which tells the four divisors apart and shows the prescaler starts from a cleared phase. Event pulses are checked one clock before and on the fifth clock. This separates the correct latency from an off-by-one in the synchroniser or delay line, and shows that falling edges and the idle prescaler add no steps. Small reload values take the counter through end-of-count in both modes, and the bench checks what it becomes next (reload or a parked zero). Byte reads taken across a high-byte borrow show whether the latched high byte stays coherent while the live low byte keeps moving.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int CW = 2 * DW;
  localparam int PW = 8;
  localparam int EVT_LAT = 5;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_SRC  = 3'd1;
  localparam logic [AW-1:0] A_LO   = 3'd2;
  localparam logic [AW-1:0] A_HI   = 3'd3;
  localparam logic [AW-1:0] A_STAT = 3'd4;

  localparam int CB_EN   = 0;
  localparam int CB_RST  = 1;
  localparam int CB_CONT = 2;
  localparam int CB_PS0  = 3;
  localparam int CB_PS1  = 4;
  localparam int CB_IE   = 6;
  localparam logic [DW-1:0] CTRL_MASK = 8'h5F;

  // low-bit mask of the prescaler phase; tick when all mask bits are one
  function automatic logic [PW-1:0] ps_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    ps_mask = 8'h03;
      2'd1:    ps_mask = 8'h0F;
      2'd2:    ps_mask = 8'h3F;
      default: ps_mask = 8'hFF;
    endcase
  endfunction

  // value after one tick
  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] cnt,
                                               input logic [CW-1:0] rel,
                                               input logic cont);
    if (cnt == CW'(1)) step_count = cont ? rel : '0;
    else               step_count = cnt - CW'(1);
  endfunction
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import rtm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [CW-1:0] count,
  input  logic          eoc,
  input  logic          hw_stop,
  output logic          en,
  output logic          restart,
  output logic          cont,
  output logic [1:0]    ps_sel,
  output logic          ie,
  output logic          src_evt,
  output logic [CW-1:0] reload,
  output logic          flag
);
  logic [DW-1:0] ctrl_q;
  logic          src_q;
  logic [DW-1:0] rel_lo_q, rel_hi_q;
  logic [DW-1:0] hi_snap_q;
  logic          flag_q;

  logic wr_ctrl, wr_src, wr_lo, wr_hi, rd_lo, rd_stat;
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_src  = wr_en && (addr == A_SRC);
  assign wr_lo   = wr_en && (addr == A_LO);
  assign wr_hi   = wr_en && (addr == A_HI);
  assign rd_lo   = rd_en && (addr == A_LO);
  assign rd_stat = rd_en && (addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wdata & CTRL_MASK;
    end else begin
      ctrl_q[CB_RST] <= 1'b0;
      if (hw_stop) ctrl_q[CB_EN] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= 1'b0;
      rel_lo_q <= '0;
      rel_hi_q <= '0;
    end else begin
      if (wr_src) src_q    <= wdata[0];
      if (wr_lo)  rel_lo_q <= wdata;
      if (wr_hi)  rel_hi_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_snap_q <= '0;
    else if (rd_lo) hi_snap_q <= count[CW-1:DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (eoc)     flag_q <= 1'b1;
    else if (rd_stat) flag_q <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_SRC:   rdata = {{(DW-1){1'b0}}, src_q};
      A_LO:    rdata = count[DW-1:0];
      A_HI:    rdata = hi_snap_q;
      A_STAT:  rdata = {{(DW-1){1'b0}}, flag_q};
      default: rdata = '0;
    endcase
  end

  assign en      = ctrl_q[CB_EN];
  assign restart = ctrl_q[CB_RST];
  assign cont    = ctrl_q[CB_CONT];
  assign ps_sel  = {ctrl_q[CB_PS1], ctrl_q[CB_PS0]};
  assign ie      = ctrl_q[CB_IE];
  assign src_evt = src_q;
  assign reload  = {rel_hi_q, rel_lo_q};
  assign flag    = flag_q;
endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
  import rtm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic       src_evt,
  input  logic [1:0] ps_sel,
  input  logic       evt_pin,
  output logic       tick
);
  // three sync/edge stages, the rest is a delay line to a fixed latency
  localparam int DLY = EVT_LAT - 3;

  logic [PW-1:0] pre_q;
  logic [2:0]    sync_q;
  logic [DLY-1:0] dly_q;
  logic          rise;
  logic          tick_sys, tick_evt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en || restart || src_evt) pre_q <= '0;
    else                                     pre_q <= pre_q + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], evt_pin};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) dly_q[0] <= 1'b0;
    else        dly_q[0] <= rise;
  end

  for (genvar i = 1; i < DLY; i++) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n) dly_q[i] <= 1'b0;
      else        dly_q[i] <= dly_q[i-1];
    end
  end

  assign tick_sys = ~src_evt & ((pre_q & ps_mask(ps_sel)) == ps_mask(ps_sel));
  assign tick_evt = src_evt & dly_q[DLY-1];
  assign tick     = en & (tick_sys | tick_evt);
endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import rtm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          cont,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count,
  output logic          eoc,
  output logic          stop
);
  logic [CW-1:0] cnt_q;

  assign eoc  = tick & ~restart & (cnt_q == CW'(1));
  assign stop = eoc & ~cont;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= reload;
    else if (tick)    cnt_q <= step_count(cnt_q, reload, cont);
  end

  assign count = cnt_q;
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import rtm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          evt_pin,
  output logic          irq
);
  logic          en_w, restart_w, cont_w, ie_w, src_w, flag_w;
  logic [1:0]    ps_w;
  logic [CW-1:0] reload_w, count_w;
  logic          tick_w, eoc_w, stop_w;

  timer_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .count(count_w), .eoc(eoc_w),
    .hw_stop(stop_w), .en(en_w), .restart(restart_w), .cont(cont_w),
    .ps_sel(ps_w), .ie(ie_w), .src_evt(src_w), .reload(reload_w),
    .flag(flag_w)
  );

  timer_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .en(en_w), .restart(restart_w),
    .src_evt(src_w), .ps_sel(ps_w), .evt_pin(evt_pin), .tick(tick_w)
  );

  timer_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .restart(restart_w),
    .cont(cont_w), .reload(reload_w), .count(count_w), .eoc(eoc_w),
    .stop(stop_w)
  );

  assign irq = flag_w & ie_w;
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import rtm_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          tick,
  input logic          restart,
  input logic          eoc,
  input logic          cont,
  input logic          en,
  input logic [CW-1:0] count,
  input logic [CW-1:0] reload,
  input logic          flag
);
  // R3
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == $past(reload));

  // R5
  step_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(count));

  // R10
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> $stable(count));

  // R6
  cont_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && cont) |=> count == $past(reload));

  // R7
  oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !cont && !(wr_en && addr == A_CTRL)) |=> (count == '0 && !en));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> flag);
endmodule

bind reload_timer16 timer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .tick(tick_w),
  .restart(restart_w), .eoc(eoc_w), .cont(cont_w), .en(en_w),
  .count(count_w), .reload(reload_w), .flag(flag_w)
);

// File: tb/sim_reload_timer16.sv
module sim_reload_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       evt_pin = 1'b0;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  reload_timer16 u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_pin(evt_pin), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic load(input logic [15:0] v);
    wr(3'd2, v[7:0]);
    wr(3'd3, v[15:8]);
    wr(3'd0, 8'h02);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    peek(3'd0, d); chk("R1 ctrl", d, 8'h00);
    peek(3'd1, d); chk("R1 src", d, 8'h00);
    peek(3'd2, d); chk("R1 count lo", d, 8'h00);
    peek(3'd4, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    wr(3'd0, 8'h02);
    @(negedge clk);
    peek(3'd2, d); chk("R1 reload lo zero", d, 8'h00);
  endtask

  task automatic t_restart;
    logic [7:0] d;
    wr(3'd2, 8'h34);
    wr(3'd3, 8'h12);
    peek(3'd2, d); chk("R2 write leaves count", d, 8'h00);
    wr(3'd0, 8'h02);
    peek(3'd2, d); chk("R3 not before next edge", d, 8'h00);
    @(negedge clk);
    peek(3'd2, d); chk("R3 loaded lo", d, 8'h34);
    peek(3'd0, d); chk("R3 restart bit self clears", d, 8'h00);
    rd(3'd2, d); chk("R2 read lo returns count", d, 8'h34);
    rd(3'd3, d); chk("R2 read hi returns count", d, 8'h12);
  endtask

  task automatic t_prescale;
    logic [7:0] d;
    for (int s = 0; s < 4; s++) begin
      int div;
      div = 4 << (2 * s);
      load(16'h0010);
      wr(3'd0, 8'h05 | 8'(s << 3));
      repeat (div - 1) @(negedge clk);
      peek(3'd2, d); chk("R4 before first step", d, 8'h10);
      @(negedge clk);
      peek(3'd2, d); chk("R4 first step", d, 8'h0F);
      repeat (div - 1) @(negedge clk);
      peek(3'd2, d); chk("R4 before second step", d, 8'h0F);
      @(negedge clk);
      peek(3'd2, d); chk("R4 second step", d, 8'h0E);
      wr(3'd0, 8'h00);
    end
  endtask

  task automatic t_freeze;
    logic [7:0] d;
    load(16'h0020);
    wr(3'd0, 8'h05);
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h04);
    peek(3'd2, d); chk("R10 value at disable", d, 8'h1F);
    repeat (30) @(negedge clk);
    peek(3'd2, d); chk("R10 frozen, no reload", d, 8'h1F);
  endtask

  task automatic t_continuous;
    logic [7:0] d;
    load(16'h0003);
    wr(3'd0, 8'h45);
    repeat (11) @(negedge clk);
    peek(3'd2, d); chk("R6 count at one", d, 8'h01);
    peek(3'd4, d); chk("R8 flag clear before eoc", d, 8'h00);
    chk("R9 irq low before eoc", {7'd0, irq}, 8'h00);
    @(negedge clk);
    peek(3'd2, d); chk("R6 reloaded", d, 8'h03);
    peek(3'd4, d); chk("R8 flag set", d, 8'h01);
    chk("R9 irq high", {7'd0, irq}, 8'h01);
    rd(3'd4, d); chk("R8 read returns flag", d, 8'h01);
    chk("R9 irq drops after read", {7'd0, irq}, 8'h00);
    peek(3'd4, d); chk("R8 read clears flag", d, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_oneshot;
    logic [7:0] d;
    load(16'h0002);
    wr(3'd0, 8'h01);
    repeat (8) @(negedge clk);
    peek(3'd2, d); chk("R7 parked at zero", d, 8'h00);
    peek(3'd0, d); chk("R7 enable cleared", d, 8'h00);
    peek(3'd4, d); chk("R8 flag on one-shot eoc", d, 8'h01);
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    repeat (20) @(negedge clk);
    peek(3'd2, d); chk("R7 stays zero", d, 8'h00);
    rd(3'd4, d);
  endtask

  task automatic t_event;
    logic [7:0] d;
    load(16'h0010);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h05);
    @(negedge clk);
    evt_pin = 1'b1;
    repeat (4) @(negedge clk);
    peek(3'd2, d); chk("R5 no step at fourth edge", d, 8'h10);
    @(negedge clk);
    peek(3'd2, d); chk("R5 step at fifth edge", d, 8'h0F);
    repeat (2) @(negedge clk);
    evt_pin = 1'b0;
    repeat (12) @(negedge clk);
    peek(3'd2, d); chk("R5 no step on fall or prescaler", d, 8'h0F);
    evt_pin = 1'b1;
    repeat (5) @(negedge clk);
    peek(3'd2, d); chk("R5 second pulse", d, 8'h0E);
    evt_pin = 1'b0;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_coherent;
    logic [7:0] d;
    load(16'h0200);
    wr(3'd0, 8'h05);
    @(negedge clk);
    rd(3'd2, d); chk("R11 low before borrow", d, 8'h00);
    rd(3'd3, d); chk("R11 latched high", d, 8'h02);
    peek(3'd3, d); chk("R11 latch holds after borrow", d, 8'h02);
    peek(3'd2, d); chk("R11 live low moved", d, 8'hFF);
    rd(3'd2, d); chk("R11 second low", d, 8'hFF);
    rd(3'd3, d); chk("R11 second high", d, 8'h01);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_restart();
    t_prescale();
    t_freeze();
    t_continuous();
    t_oneshot();
    t_event();
    t_coherent();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule